// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit executes the atomic store-class operations of a register virtual machine against a single-port, byte-addressed memory. One request carries the operation code (an immediate field), the access size (32 or 64 bits), the destination register's value used as a base address, a signed 16-bit displacement, the source register's value and index, and the current value of register 0. The unit reads the target location, computes the new value, writes it back when the operation calls for it, and then reports any register update on a write-back port.

Supported operations are add, or, and, xor (each optionally returning the prior memory value into the source register), exchange, and compare-exchange. Compare-exchange uses register 0 as the comparand and always reloads register 0 with the prior memory value. Throughout the read-to-write window the unit raises a lock output so the memory side can keep any other agent out. Illegal operation codes and misaligned addresses end the request with an error response, without touching memory or registers.

Top module: `atomic_rmw_unit`

## Requirements
- R1: The byte address presented on `mem_addr` is `req_base` plus `req_offset` sign-extended to 64 bits; a 32-bit access uses bits 31:0 of `mem_rdata`/`mem_wdata` and `mem_dword` is 0, a 64-bit access uses all 64 bits and `mem_dword` is 1.
- R2: With bits 31:8 of `req_imm` zero and bits 3:1 zero, bits 7:4 select the operation: 0x0 add, 0x4 or, 0x5 and, 0xa xor, 0xe exchange, 0xf compare-exchange; the stored value is the old memory value combined with the source value at the access width (add wraps).
- R3: Bit 0 of `req_imm` is the fetch flag: when set, the unit reports a write-back of the old memory value to register `req_src_idx` (`wb_idx`); when clear, no write-back is reported.
- R4: Exchange (0xe1) stores the source value and returns the old memory value to the source register.
- R5: Compare-exchange (0xf1) stores the source value only when the old memory value equals register 0; in both outcomes it writes the old value to register 0 (`wb_idx` = 0).
- R6: For 32-bit operations only the low 32 bits of the source and of register 0 take part, and a fetched value is zero-extended to 64 bits.
- R7: Any other code (including 0xe0, 0xf0, odd bits 3:1 or any bit above 7) yields `resp_err` = 1 with no memory read or write and no write-back.
- R8: An address not aligned to the access size (4 or 8 bytes) yields `resp_err` = 1 with no memory access and no write-back.
- R9: For a legal request accepted at clock edge N, `mem_rd_en` is high in the cycle after N, the read data is taken in the following cycle, `mem_wr_en` (when storing) is high in the third cycle, and `resp_valid` (with any write-back) in the fourth; `mem_lock` is high exactly across those first three cycles. Read data must appear on `mem_rdata` the cycle after `mem_rd_en`.
- R10: `req_ready` is high only when idle; a request is taken when `req_valid` and `req_ready` are both high, and `req_valid` during a busy sequence has no effect.
- R11: An error response appears in the cycle after acceptance, and after reset the unit is idle with `req_ready` high and all memory, response and write-back strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_imm | input | 32 | Operation code field |
| req_dword | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| req_base | input | 64 | Destination register value (base address) |
| req_offset | input | 16 | Signed displacement |
| req_src | input | 64 | Source register value |
| req_src_idx | input | 4 | Source register index |
| req_r0 | input | 64 | Register 0 value (comparand) |
| mem_addr | output | 64 | Byte address |
| mem_rd_en | output | 1 | Read strobe |
| mem_wr_en | output | 1 | Write strobe |
| mem_dword | output | 1 | Access size, 1 = 64-bit |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after the read strobe |
| mem_lock | output | 1 | Held from read through write |
| wb_valid | output | 1 | Register write-back present |
| wb_idx | output | 4 | Register to write |
| wb_data | output | 64 | Value to write |
| resp_valid | output | 1 | Request finished |
| resp_err | output | 1 | Request rejected |

## Verification
The bench sweeps every legal code at both sizes over data patterns that include carry out of bit 31 and bit 63, so a unit that added at the wrong width would corrupt the neighbouring word or fail to wrap. It checks compare-exchange with matching and mismatching comparands, including a 32-bit case where register 0 differs only in its upper half: a unit comparing all 64 bits would skip the store there, and one storing unconditionally would overwrite memory on a mismatch. All 256 low codes plus codes with high bits set are tried, catching a decoder that accepted exchange without the fetch bit or ignored upper bits, and displacements around the base catch sign-extension and alignment mistakes. Lock coverage, response latency and a request held during a busy sequence are watched on every run.

// File: rtl/armw_pkg.sv
package armw_pkg;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_OR,
    OP_AND,
    OP_XOR,
    OP_XCHG,
    OP_CMPXCHG
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CALC,
    ST_WRITE,
    ST_RESP,
    ST_FAIL
  } seq_state_e;

  // Operation codes with the fetch bit cleared.
  localparam logic [7:0] CODE_ADD  = 8'h00;
  localparam logic [7:0] CODE_OR   = 8'h40;
  localparam logic [7:0] CODE_AND  = 8'h50;
  localparam logic [7:0] CODE_XOR  = 8'ha0;
  localparam logic [7:0] CODE_XCHG = 8'he0;
  localparam logic [7:0] CODE_CAS  = 8'hf0;
  localparam int         FETCH_BIT = 0;

endpackage

// File: rtl/armw_decode.sv
module armw_decode
  import armw_pkg::*;
#(
  parameter int IMM_W  = 32,
  parameter int ADDR_W = 64
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  output amo_op_e           op_o,
  output logic              fetch_o,
  output logic              code_bad_o,
  output logic              misalign_o
);

  logic       upper_clear;
  logic [7:0] base_code;

  assign upper_clear = (imm_i[IMM_W-1:8] == '0);
  assign base_code   = {imm_i[7:1], 1'b0};
  assign fetch_o     = imm_i[FETCH_BIT];

  always_comb begin
    op_o       = OP_ADD;
    code_bad_o = !upper_clear;
    case (base_code)
      CODE_ADD: op_o = OP_ADD;
      CODE_OR:  op_o = OP_OR;
      CODE_AND: op_o = OP_AND;
      CODE_XOR: op_o = OP_XOR;
      CODE_XCHG: begin
        op_o = OP_XCHG;
        if (!imm_i[FETCH_BIT]) code_bad_o = 1'b1;
      end
      CODE_CAS: begin
        op_o = OP_CMPXCHG;
        if (!imm_i[FETCH_BIT]) code_bad_o = 1'b1;
      end
      default: code_bad_o = 1'b1;
    endcase
  end

  assign misalign_o = wide_i ? (addr_i[2:0] != 3'b000) : (addr_i[1:0] != 2'b00);

endmodule

// File: rtl/armw_alu.sv
module armw_alu
  import armw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  amo_op_e           op_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] cmp_i,
  output logic [DATA_W-1:0] old_o,
  output logic [DATA_W-1:0] new_o,
  output logic              store_o
);

  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};

  logic [DATA_W-1:0] size_mask;
  logic [DATA_W-1:0] src_m;
  logic [DATA_W-1:0] cmp_m;
  logic [DATA_W-1:0] raw;

  assign size_mask = wide_i ? '1 : NARROW_MASK;
  assign old_o     = mem_i & size_mask;
  assign src_m     = src_i & size_mask;
  assign cmp_m     = cmp_i & size_mask;

  always_comb begin
    raw     = src_m;
    store_o = 1'b1;
    case (op_i)
      OP_ADD:     raw = old_o + src_m;
      OP_OR:      raw = old_o | src_m;
      OP_AND:     raw = old_o & src_m;
      OP_XOR:     raw = old_o ^ src_m;
      OP_XCHG:    raw = src_m;
      OP_CMPXCHG: begin
        raw     = src_m;
        store_o = (old_o == cmp_m);
      end
      default:    raw = src_m;
    endcase
  end

  assign new_o = raw & size_mask;

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import armw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int IMM_W  = 32,
  parameter int OFF_W  = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic              req_dword,
  input  logic [DATA_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_src,
  input  logic [IDX_W-1:0]  req_src_idx,
  input  logic [DATA_W-1:0] req_r0,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic              mem_dword,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_lock,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic              resp_valid,
  output logic              resp_err
);

  localparam int EXT_W = DATA_W - OFF_W;

  seq_state_e        state_q, state_d;
  logic [DATA_W-1:0] eff_addr;
  amo_op_e           dec_op;
  logic              dec_fetch, dec_bad, dec_misalign;
  logic              accept, calc_en;

  amo_op_e           op_q;
  logic              fetch_q, wide_q, store_q;
  logic [DATA_W-1:0] addr_q, src_q, r0_q, old_q, new_q;
  logic [IDX_W-1:0]  idx_q;

  logic [DATA_W-1:0] alu_old, alu_new;
  logic              alu_store;

  assign eff_addr = req_base + {{EXT_W{req_offset[OFF_W-1]}}, req_offset};

  armw_decode #(
    .IMM_W (IMM_W),
    .ADDR_W(DATA_W)
  ) u_decode (
    .imm_i     (req_imm),
    .wide_i    (req_dword),
    .addr_i    (eff_addr),
    .op_o      (dec_op),
    .fetch_o   (dec_fetch),
    .code_bad_o(dec_bad),
    .misalign_o(dec_misalign)
  );

  armw_alu #(
    .DATA_W(DATA_W),
    .WORD_W(WORD_W)
  ) u_alu (
    .op_i   (op_q),
    .wide_i (wide_q),
    .mem_i  (mem_rdata),
    .src_i  (src_q),
    .cmp_i  (r0_q),
    .old_o  (alu_old),
    .new_o  (alu_new),
    .store_o(alu_store)
  );

  assign accept  = req_valid && (state_q == ST_IDLE);
  assign calc_en = (state_q == ST_CALC);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid) state_d = (dec_bad || dec_misalign) ? ST_FAIL : ST_READ;
      ST_READ:  state_d = ST_CALC;
      ST_CALC:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      ST_FAIL:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_ADD;
      fetch_q <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      src_q   <= '0;
      r0_q    <= '0;
      idx_q   <= '0;
    end else if (accept) begin
      op_q    <= dec_op;
      fetch_q <= dec_fetch;
      wide_q  <= req_dword;
      addr_q  <= eff_addr;
      src_q   <= req_src;
      r0_q    <= req_r0;
      idx_q   <= req_src_idx;
    end
  end

  // Result capture, enabled in the compute cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q   <= '0;
      new_q   <= '0;
      store_q <= 1'b0;
    end else if (calc_en) begin
      old_q   <= alu_old;
      new_q   <= alu_new;
      store_q <= alu_store;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign mem_addr   = addr_q;
  assign mem_dword  = wide_q;
  assign mem_wdata  = new_q;
  assign mem_rd_en  = (state_q == ST_READ);
  assign mem_wr_en  = (state_q == ST_WRITE) && store_q;
  assign mem_lock   = (state_q == ST_READ) || (state_q == ST_CALC) || (state_q == ST_WRITE);
  assign resp_valid = (state_q == ST_RESP) || (state_q == ST_FAIL);
  assign resp_err   = (state_q == ST_FAIL);
  assign wb_valid   = (state_q == ST_RESP) && fetch_q;
  assign wb_idx     = (op_q == OP_CMPXCHG) ? '0 : idx_q;
  assign wb_data    = old_q;

  // R9: every memory strobe sits inside the locked window
  a_r9_lock_covers_access: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> mem_lock);

  // R9: the lock window always opens with the read
  a_r9_lock_opens_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_lock) |-> mem_rd_en);

  // R9: a store comes two cycles after its read
  a_r9_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en, 2));

  // R9: the response follows the locked window directly
  a_r9_resp_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_lock) |-> (resp_valid && !resp_err));

  // R7 / R8: a rejected request touched neither memory nor registers
  a_r7_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_err) |-> (!wb_valid && !$past(mem_lock)));

  // R3: write-back only accompanies a successful response
  a_r3_wb_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (resp_valid && !resp_err));

  // R10: ready only while nothing is in flight
  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_lock && !resp_valid));

  // R5: compare-exchange reports register 0
  a_r5_cas_r0: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && (op_q == OP_CMPXCHG)) |-> (wb_idx == '0));

endmodule

// File: tb/atomic_rmw_unit_bench.sv
module atomic_rmw_unit_bench;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_imm;
  logic        req_dword;
  logic [63:0] req_base;
  logic [15:0] req_offset;
  logic [63:0] req_src;
  logic [3:0]  req_src_idx;
  logic [63:0] req_r0;
  logic [63:0] mem_addr;
  logic        mem_rd_en;
  logic        mem_wr_en;
  logic        mem_dword;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata;
  logic        mem_lock;
  logic        wb_valid;
  logic [3:0]  wb_idx;
  logic [63:0] wb_data;
  logic        resp_valid;
  logic        resp_err;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit finished = 0;

  logic [7:0]  mem [64];
  logic        pre_en;
  logic [63:0] pre_addr;
  logic [63:0] pre_data;

  atomic_rmw_unit u_atomic_rmw_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_imm(req_imm),
    .req_dword(req_dword), .req_base(req_base), .req_offset(req_offset),
    .req_src(req_src), .req_src_idx(req_src_idx), .req_r0(req_r0),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_dword(mem_dword), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_lock(mem_lock), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .resp_valid(resp_valid), .resp_err(resp_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [63:0] peek(input logic [63:0] a, input bit w);
    logic [63:0] v = '0;
    for (int i = 0; i < (w ? 8 : 4); i++) v[8*i +: 8] = mem[(a[5:0] + 6'(i))];
    return v;
  endfunction

  // Memory model: read data the cycle after the strobe, little-endian bytes
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= peek(mem_addr, mem_dword);
    if (mem_wr_en)
      for (int i = 0; i < (mem_dword ? 8 : 4); i++) mem[mem_addr[5:0] + 6'(i)] <= mem_wdata[8*i +: 8];
    if (pre_en)
      for (int i = 0; i < 8; i++) mem[pre_addr[5:0] + 6'(i)] <= pre_data[8*i +: 8];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not end, actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [63:0] a, input logic [63:0] d);
    @(negedge clk);
    pre_en = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  function automatic bit legal_code(input logic [31:0] imm);
    return imm inside {32'h00, 32'h01, 32'h40, 32'h41, 32'h50, 32'h51,
                       32'ha0, 32'ha1, 32'he1, 32'hf1};
  endfunction

  task automatic run_op(input logic [31:0] imm, input bit w, input logic [63:0] base,
                        input logic [15:0] off, input logic [63:0] src, input logic [3:0] sidx,
                        input logic [63:0] r0, input logic [63:0] init, input bit poke);
    logic [63:0] addr, aligned, m, old, s, c, nv, exp_region, got_region;
    logic [7:0]  opb;
    bit bad, store, exp_wb, seen_wb, got_err;
    int k, viol, writes, lat;
    logic [3:0]  got_idx;
    logic [63:0] got_data;
    addr    = base + {{48{off[15]}}, off};
    aligned = {addr[63:3], 3'b000};
    bad     = !legal_code(imm) || (w ? (addr[2:0] != 0) : (addr[1:0] != 0));
    preload(aligned, init);
    m   = w ? 64'hffff_ffff_ffff_ffff : 64'h0000_0000_ffff_ffff;
    old = peek(addr, w);
    s   = src & m;
    c   = r0 & m;
    opb = {imm[7:1], 1'b0};
    case (opb)
      8'h00:   nv = (old + s) & m;
      8'h40:   nv = old | s;
      8'h50:   nv = old & s;
      8'ha0:   nv = old ^ s;
      default: nv = s;
    endcase
    store = (opb != 8'hf0) || (old == c);
    exp_region = init;
    if (!bad && store)
      for (int i = 0; i < (w ? 8 : 4); i++) exp_region[8*(addr[2:0] + 3'(i)) +: 8] = nv[8*i +: 8];
    exp_wb = !bad && imm[0];

    @(negedge clk);
    req_valid = 1'b1; req_imm = imm; req_dword = w; req_base = base; req_offset = off;
    req_src = src; req_src_idx = sidx; req_r0 = r0;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1; viol = 0; writes = 0; lat = -1; seen_wb = 0; got_err = 0; got_idx = '0; got_data = '0;
    while (k < 12) begin
      if ((mem_rd_en || mem_wr_en) && !mem_lock) viol++;
      if (mem_wr_en) writes++;
      if (bad && (mem_rd_en || mem_lock)) viol++;
      if (k == 1 && !bad) begin
        // R10: busy while the sequence runs; a request now must be ignored
        chk(req_ready == 1'b0, "R10 ready low while busy", 64'(req_ready), 64'd0);
        if (poke) begin
          req_valid = 1'b1; req_imm = 32'he1; req_src = ~src; req_base = base + 64'd8;
        end
      end
      if (resp_valid) begin
        lat = k; got_err = resp_err; seen_wb = wb_valid; got_idx = wb_idx; got_data = wb_data;
        req_valid = 1'b0;
        break;
      end
      @(negedge clk);
      k++;
    end
    chk(lat == (bad ? 1 : 4), "R9/R11 response latency", 64'(lat), bad ? 64'd1 : 64'd4);
    chk(got_err == bad, bad ? "R7/R8 error flagged" : "R2 no error", 64'(got_err), 64'(bad));
    chk(viol == 0, "R9 lock covers access / R7 no access on error", 64'(viol), 64'd0);
    chk(writes == ((!bad && store) ? 1 : 0), "R5/R7 store count", 64'(writes), 64'((!bad && store) ? 1 : 0));
    chk(seen_wb == exp_wb, "R3 write-back presence", 64'(seen_wb), 64'(exp_wb));
    if (exp_wb) begin
      chk(got_idx == ((opb == 8'hf0) ? 4'd0 : sidx), "R3/R5 write-back register",
          64'(got_idx), 64'((opb == 8'hf0) ? 4'd0 : sidx));
      chk(got_data == old, "R4/R6 fetched old value", got_data, old);
    end
    @(negedge clk);
    got_region = peek(aligned, 1'b1);
    chk(got_region == exp_region, "R1/R2/R5 memory after op", got_region, exp_region);
    if (poke) begin
      int extra = 0;
      for (int j = 0; j < 3; j++) begin
        if (resp_valid || mem_lock) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R10 request during busy ignored", 64'(extra), 64'd0);
    end
  endtask

  initial begin
    logic [31:0] codes [10];
    logic [63:0] pat_old, pat_src;
    codes = '{32'h00, 32'h01, 32'h40, 32'h41, 32'h50, 32'h51, 32'ha0, 32'ha1, 32'he1, 32'hf1};
    rst_n = 1'b0; req_valid = 1'b0; req_imm = '0; req_dword = 1'b0; req_base = '0;
    req_offset = '0; req_src = '0; req_src_idx = '0; req_r0 = '0; pre_en = 1'b0;
    pre_addr = '0; pre_data = '0; mem_rdata = '0;
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37);
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(req_ready == 1'b1, "R11 ready after reset", 64'(req_ready), 64'd1);
    chk({mem_rd_en, mem_wr_en, mem_lock, resp_valid, wb_valid} == 5'b0,
        "R11 strobes low in reset", 64'({mem_rd_en, mem_wr_en, mem_lock, resp_valid, wb_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !resp_valid, "R11 idle after release", 64'(req_ready), 64'd1);

    // R2 R3 R4 R6: every legal code, both sizes, several patterns
    for (int p = 0; p < 4; p++) begin
      case (p)
        0: begin pat_old = 64'hffff_ffff_ffff_ffff; pat_src = 64'h0000_0000_0000_0001; end
        1: begin pat_old = 64'h0123_4567_89ab_cdef; pat_src = 64'hf0f0_0f0f_3c3c_a5a5; end
        2: begin pat_old = 64'h8000_0000_7fff_ffff; pat_src = 64'h8000_0001_8000_0001; end
        default: begin pat_old = 64'h5555_aaaa_0000_ffff; pat_src = 64'hdead_beef_cafe_f00d; end
      endcase
      for (int ci = 0; ci < 10; ci++) begin
        run_op(codes[ci], 1'b1, 64'h20, 16'h0008, pat_src, 4'(ci + 1), ~pat_old, pat_old, p == 1);
        run_op(codes[ci], 1'b0, 64'h20, 16'hfffc, pat_src, 4'(ci + 2), ~pat_old, pat_old, 1'b0);
        run_op(codes[ci], 1'b0, 64'h18, 16'h0000, pat_src, 4'(ci + 3), pat_old, pat_old, 1'b0);
      end
    end

    // R5: compare-exchange matching and not matching, R6 upper half ignored
    run_op(32'hf1, 1'b1, 64'h10, 16'h0000, 64'h1111_2222_3333_4444, 4'd5, 64'h0bad_cafe_1234_5678,
           64'h0bad_cafe_1234_5678, 1'b0);
    run_op(32'hf1, 1'b1, 64'h10, 16'h0000, 64'h1111_2222_3333_4444, 4'd5, 64'h0bad_cafe_1234_5679,
           64'h0bad_cafe_1234_5678, 1'b0);
    run_op(32'hf1, 1'b0, 64'h14, 16'h0000, 64'h9999_8888_7777_6666, 4'd7, 64'hffff_ffff_1234_5678,
           64'h1234_5678_0000_0000, 1'b0);
    run_op(32'hf1, 1'b0, 64'h10, 16'h0004, 64'h9999_8888_7777_6666, 4'd7, 64'h0000_0000_1234_5670,
           64'h1234_5678_0000_0000, 1'b0);

    // R7: every low code, plus high bits set
    for (int v = 0; v < 256; v++)
      run_op(32'(v), 1'b1, 64'h28, 16'h0000, 64'h0f0f_0f0f_0f0f_0f0f, 4'd3, 64'h0, 64'h1234_5678_9abc_def0, 1'b0);
    run_op(32'h0000_0100, 1'b1, 64'h28, 16'h0000, 64'h1, 4'd3, 64'h0, 64'h77, 1'b0);
    run_op(32'h8000_00a1, 1'b0, 64'h28, 16'h0000, 64'h1, 4'd3, 64'h0, 64'h77, 1'b0);

    // R1 R8: displacements around the base, both signs, both sizes
    for (int d = -12; d <= 12; d++) begin
      run_op(32'h01, 1'b1, 64'h20, 16'(d), 64'h0000_0001_0000_0001, 4'd9, 64'h0, 64'h0102_0304_0506_0708, 1'b0);
      run_op(32'h01, 1'b0, 64'h20, 16'(d), 64'h0000_0001_0000_0001, 4'd9, 64'h0, 64'h0102_0304_0506_0708, 1'b0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule